// File: doc/BRIEF.md
# Single-Byte I2C Target Responder

This block is the target side of an I2C bus, limited to transfers that carry exactly one data byte. It watches the open-drain clock and data lines. After a start condition it shifts in a 7-bit address and a direction bit. It then answers on SDA with an acknowledge level that it takes from an input pin. For a write it receives one byte and answers it with a second acknowledge level, also taken from a pin. For a read it sends a byte presented on an input bus and then records whether the controller acknowledged it. The block does not compare the address with an own address. The surrounding logic decides both acknowledges, so it can inject a NACK at either phase on purpose.

Both bus lines pass through a two-flop synchroniser, and every decision is made on edges of the synchronised values. The block touches SDA only through `sda_pull_o`, which pulls the line low when high. It changes this signal only while SCL is low. When a transfer reaches its acknowledge clock, the captured fields appear on the report outputs together with a one-cycle `rep_valid_o` pulse. The report path has no back-pressure. A consumer must take the fields in the cycle of the pulse, and they stay steady until the next transfer begins.

Top module: `i2c_byte_target`

## Requirements
- R1: While `rst` is high and afterwards until a start is seen, `sda_pull_o` is 0 and `rep_valid_o` is 0. A reset in the middle of a transfer releases SDA within two clock cycles.
- R2: Nothing happens on the bus until SDA falls while SCL is high. SCL pulses without a preceding start never cause SDA to be pulled.
- R3: After a start, the first 7 SCL rising edges carry the address MSB first. The 8th rising edge carries the direction, where 0 means write and 1 means read. Both are reported in `rep_addr_o` and `rep_read_o`.
- R4: In the 9th SCL clock after a start, SDA is pulled low when `addr_nack_i` is 0 (ACK) and left released when it is 1 (NACK).
- R5: After an address NACK, the block neither pulls SDA nor produces a report until the next start.
- R6: On a write, the next 8 rising edges carry the data byte MSB first, reported in `rep_data_o`. In the clock that follows, SDA is pulled low when `data_nack_i` is 0 and released when it is 1.
- R7: On a read, `tx_byte_i` is sampled when the address acknowledge clock ends. It is then driven MSB first over 8 SCL clocks, where a 0 bit pulls SDA and a 1 bit releases it. SDA is released afterwards.
- R8: The SDA level at the 9th rising edge of the data phase is reported in `rep_ack_o`, where 0 means ACK. On a read this is the controller's acknowledge. On a write it is the level the block itself placed.
- R9: Each completed data phase produces exactly one `rep_valid_o` pulse, one clock wide, at the rising SCL edge of the data acknowledge clock.
- R10: `sda_pull_o` changes only while the synchronised SCL is low, except when reset, a start or a stop forces a release.
- R11: A start or a stop seen during a transfer abandons it without a report. A start begins a new address phase from bit zero, and a stop returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_nack_i | input | 1 | Address acknowledge response: 0 ACK, 1 NACK |
| data_nack_i | input | 1 | Write-data acknowledge response: 0 ACK, 1 NACK |
| tx_byte_i | input | DATA_W | Byte returned on a read |
| rep_valid_o | output | 1 | One-cycle pulse: report fields are valid |
| rep_addr_o | output | ADDR_W | Captured address |
| rep_read_o | output | 1 | Captured direction, 1 = read |
| rep_data_o | output | DATA_W | Received (write) or sent (read) byte |
| rep_ack_o | output | 1 | SDA level in the data acknowledge clock |

## Verification
A bit-level controller model drives writes and reads against addresses and bytes with alternating, all-zero and all-one patterns. It checks the SDA level in every clock where the target answers, so a bit-order mistake shows up apart from an acknowledge polarity mistake. Address NACK and data NACK are injected on their own, which separates a wrong phase choice from wrong gating of the data phase. The bench also sends clock pulses with no start, a repeated start after half an address, a stop partway through the address and another in the write data, and a reset while the block drives a read byte. Each of these shows whether the block aborts cleanly and whether the next transfer is reported correctly.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_DACK,
    ST_RDAT,
    ST_MACK
  } tgt_state_e;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  // Idle bus level is high, so every stage resets to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '1;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2ct_events.sv
module i2ct_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // Start and stop both need SCL high before and after the SDA edge.
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              addr_nack,
  input  logic              data_nack,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              sda_pull,
  output tgt_state_e        state,
  output logic              addr_nak_q,
  output logic              rep_valid,
  output logic [ADDR_W-1:0] rep_addr,
  output logic              rep_read,
  output logic [DATA_W-1:0] rep_data,
  output logic              rep_ack
);

  localparam int FRAME_BITS = ADDR_W + 1;
  localparam int MAX_BITS   = (FRAME_BITS > DATA_W) ? FRAME_BITS : DATA_W;
  localparam int CW         = $clog2(MAX_BITS + 1);

  logic [CW-1:0]         bit_cnt;
  logic [FRAME_BITS-1:0] frame_sh;
  logic [DATA_W-1:0]     rx_sh;
  logic [DATA_W-1:0]     tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      frame_sh   <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      sda_pull   <= 1'b0;
      addr_nak_q <= 1'b0;
      rep_valid  <= 1'b0;
      rep_addr   <= '0;
      rep_read   <= 1'b0;
      rep_data   <= '0;
      rep_ack    <= 1'b1;
    end else begin
      rep_valid <= 1'b0;
      if (bus_stop) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (bus_start) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              frame_sh <= {frame_sh[FRAME_BITS-2:0], sda_s};
              bit_cnt  <= bit_cnt + CW'(1);
            end else if (scl_fall && bit_cnt == CW'(FRAME_BITS)) begin
              state      <= ST_AACK;
              sda_pull   <= ~addr_nack;
              addr_nak_q <= addr_nack;
              rep_addr   <= frame_sh[FRAME_BITS-1:1];
              rep_read   <= frame_sh[0];
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (addr_nak_q) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
              end else if (rep_read) begin
                state    <= ST_RDAT;
                sda_pull <= ~tx_byte[DATA_W-1];
                tx_sh    <= {tx_byte[DATA_W-2:0], 1'b0};
                rep_data <= tx_byte;
              end else begin
                state    <= ST_WDAT;
                sda_pull <= 1'b0;
              end
            end
          end
          ST_WDAT: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[DATA_W-2:0], sda_s};
              bit_cnt <= bit_cnt + CW'(1);
            end else if (scl_fall && bit_cnt == CW'(DATA_W)) begin
              state    <= ST_DACK;
              sda_pull <= ~data_nack;
              rep_data <= rx_sh;
            end
          end
          ST_DACK: begin
            if (scl_rise) begin
              rep_valid <= 1'b1;
              rep_ack   <= sda_s;
            end else if (scl_fall) begin
              state    <= ST_IDLE;
              sda_pull <= 1'b0;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + CW'(1);
            end else if (scl_fall) begin
              if (bit_cnt == CW'(DATA_W)) begin
                state    <= ST_MACK;
                sda_pull <= 1'b0;
              end else begin
                sda_pull <= ~tx_sh[DATA_W-1];
                tx_sh    <= {tx_sh[DATA_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              rep_valid <= 1'b1;
              rep_ack   <= sda_s;
              state     <= ST_IDLE;
            end
          end
          default: begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_byte_target.sv
module i2c_byte_target
  import i2ct_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              addr_nack_i,
  input  logic              data_nack_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              rep_valid_o,
  output logic [ADDR_W-1:0] rep_addr_o,
  output logic              rep_read_o,
  output logic [DATA_W-1:0] rep_data_o,
  output logic              rep_ack_o
);

  logic [1:0] lines_s;
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_ev;
  logic       stop_ev;
  tgt_state_e eng_state;
  logic       addr_nak_q;

  i2ct_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({scl_i, sda_i}),
    .dout (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2ct_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (start_ev),
    .bus_stop  (stop_ev)
  );

  i2ct_engine #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .bus_start  (start_ev),
    .bus_stop   (stop_ev),
    .addr_nack  (addr_nack_i),
    .data_nack  (data_nack_i),
    .tx_byte    (tx_byte_i),
    .sda_pull   (sda_pull_o),
    .state      (eng_state),
    .addr_nak_q (addr_nak_q),
    .rep_valid  (rep_valid_o),
    .rep_addr   (rep_addr_o),
    .rep_read   (rep_read_o),
    .rep_data   (rep_data_o),
    .rep_ack    (rep_ack_o)
  );

endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
  import i2ct_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       sda_pull,
  input tgt_state_e st,
  input logic       anak,
  input logic       rep_valid
);

  // R1: reset leaves SDA released and no report pending.
  a_r1_reset_release: assert property (@(posedge clk)
    rst |=> (!sda_pull && !rep_valid));

  // R1: idle never pulls SDA.
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_pull);

  // R10: SDA drive moves only while SCL is low, unless forced free.
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_pull) && !$past(start_ev) && !$past(stop_ev)) |-> !scl_s);

  // R9: a report is a single-cycle pulse.
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rep_valid |=> !rep_valid);

  // R5: no report follows an address NACK.
  a_r5_nack_no_report: assert property (@(posedge clk) disable iff (rst)
    rep_valid |-> !anak);

  // R5: after an address NACK no data state is entered.
  a_r5_nack_no_data: assert property (@(posedge clk) disable iff (rst)
    (st == ST_AACK && anak) |=> (st == ST_AACK || st == ST_IDLE || st == ST_ADDR));

endmodule

bind i2c_byte_target i2ct_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_s     (scl_s),
  .start_ev  (start_ev),
  .stop_ev   (stop_ev),
  .sda_pull  (sda_pull_o),
  .st        (eng_state),
  .anak      (addr_nak_q),
  .rep_valid (rep_valid_o)
);

// File: tb/i2c_byte_target_bench.sv
module i2c_byte_target_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int DW = 8;
  localparam int H  = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          m_scl = 1'b1;
  logic          m_sda = 1'b1;
  logic          addr_nack = 1'b0;
  logic          data_nack = 1'b0;
  logic [DW-1:0] tx_byte = '0;
  logic          sda_pull;
  logic          rep_valid;
  logic [AW-1:0] rep_addr;
  logic          rep_read;
  logic [DW-1:0] rep_data;
  logic          rep_ack;
  logic          sda_line;

  int tests = 0;
  int fails = 0;
  int reports = 0;
  int r10_bad = 0;
  bit done = 1'b0;
  logic prev_pull = 1'b0;
  logic [AW+DW+1:0] exp_q[$];

  assign sda_line = m_sda & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_target #(.ADDR_W(AW), .DATA_W(DW)) u_i2c_byte_target (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (m_scl),
    .sda_i       (sda_line),
    .sda_pull_o  (sda_pull),
    .addr_nack_i (addr_nack),
    .data_nack_i (data_nack),
    .tx_byte_i   (tx_byte),
    .rep_valid_o (rep_valid),
    .rep_addr_o  (rep_addr),
    .rep_read_o  (rep_read),
    .rep_data_o  (rep_data),
    .rep_ack_o   (rep_ack)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Per-clock comparison of the report port against the expected queue.
  always @(negedge clk) begin
    if (!rst) begin
      if (sda_pull != prev_pull && m_scl) r10_bad++;
      prev_pull <= sda_pull;
      if (rep_valid) begin
        reports++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected report", 1, 0);
        end else begin
          logic [AW+DW+1:0] e;
          e = exp_q.pop_front();
          check({rep_addr, rep_read, rep_data, rep_ack} == e, "R3/R8 (R9 report)",
                "report fields", int'({rep_addr, rep_read, rep_data, rep_ack}), int'(e));
        end
      end
    end else begin
      prev_pull <= 1'b0;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold(H/2);
    m_scl = 1'b1; hold(H);
    m_sda = 1'b0; hold(H);
    m_scl = 1'b0; hold(H/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(H/2);
    m_scl = 1'b1; hold(H);
    m_sda = 1'b1; hold(H);
  endtask

  task automatic bit_slot(input bit b, output bit seen);
    m_sda = b; hold(H/2);
    m_scl = 1'b1; hold(H/2);
    seen = sda_line; hold(H/2);
    m_scl = 1'b0; hold(H/2);
  endtask

  task automatic send_frame(input logic [AW-1:0] a, input bit rd, input int nbits);
    bit s;
    logic [AW:0] fr;
    fr = {a, rd};
    for (int i = AW; i > AW - nbits; i--) bit_slot(fr[i], s);
  endtask

  task automatic xfer(input logic [AW-1:0] a, input bit rd, input bit anak,
                      input bit dnak, input bit mack, input logic [DW-1:0] d);
    bit s;
    addr_nack = anak;
    data_nack = dnak;
    tx_byte   = d;
    if (!anak) exp_q.push_back({a, rd, d, rd ? mack : dnak});
    bus_start();
    send_frame(a, rd, AW + 1);
    bit_slot(1'b1, s);
    if (anak) begin
      check(s == 1'b1, "R5", "address NACK level", s, 1);
      for (int i = 0; i < 9; i++) begin
        bit_slot(1'b1, s);
        check(s == 1'b1, "R5", "SDA released after NACK", s, 1);
      end
    end else begin
      check(s == 1'b0, "R4", "address ACK level", s, 0);
      if (!rd) begin
        for (int i = DW - 1; i >= 0; i--) bit_slot(d[i], s);
        bit_slot(1'b1, s);
        check(s == dnak, "R6", "data acknowledge level", s, dnak);
      end else begin
        for (int i = DW - 1; i >= 0; i--) begin
          bit_slot(1'b1, s);
          check(s == d[i], "R7", "read data bit", s, d[i]);
        end
        bit_slot(mack, s);
        check(s == mack, "R8", "controller ack slot", s, mack);
      end
    end
    bus_stop();
    hold(4);
    check(exp_q.size() == 0, "R9", "report delivered", exp_q.size(), 0);
  endtask

  initial begin
    bit s;
    hold(5);
    check(sda_pull == 1'b0, "R1", "SDA pull in reset", sda_pull, 0);
    check(rep_valid == 1'b0, "R1", "report in reset", rep_valid, 0);
    rst = 1'b0;
    hold(10);
    check(sda_pull == 1'b0, "R1", "SDA pull after reset", sda_pull, 0);

    // R2: clocking with no start condition must not provoke an answer.
    addr_nack = 1'b0;
    m_scl = 1'b0; hold(H/2);
    for (int i = 0; i < 8; i++) bit_slot(i[0], s);
    bit_slot(1'b1, s);
    check(s == 1'b1, "R2", "no ACK without start", s, 1);
    check(reports == 0, "R2", "no report without start", reports, 0);
    m_sda = 1'b1; hold(H/2);
    m_scl = 1'b1; hold(H);

    // Writes and reads with varied patterns (R3, R4, R6, R7, R8).
    xfer(7'h2A, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3);
    xfer(7'h7F, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    xfer(7'h51, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5);
    xfer(7'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
    xfer(7'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A);

    // R5: address NACK on a write and on a read.
    xfer(7'h7B, 1'b0, 1'b1, 1'b0, 1'b0, 8'h11);
    xfer(7'h44, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);

    // R11: repeated start after half an address.
    bus_start();
    send_frame(7'h55, 1'b0, 4);
    xfer(7'h12, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81);

    // R11: stop partway through the address.
    bus_start();
    send_frame(7'h0F, 1'b1, 5);
    bus_stop();
    hold(4);
    check(sda_pull == 1'b0, "R11", "released after stop", sda_pull, 0);
    xfer(7'h66, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3E);

    // R11: stop in the middle of write data, no report expected.
    addr_nack = 1'b0;
    bus_start();
    send_frame(7'h21, 1'b0, AW + 1);
    bit_slot(1'b1, s);
    check(s == 1'b0, "R4", "address ACK before abort", s, 0);
    for (int i = 0; i < 3; i++) bit_slot(1'b1, s);
    bus_stop();
    hold(4);
    xfer(7'h09, 1'b0, 1'b0, 1'b0, 1'b0, 8'h96);

    // R1: reset while the block drives a read byte.
    addr_nack = 1'b0;
    tx_byte = 8'h00;
    bus_start();
    send_frame(7'h30, 1'b1, AW + 1);
    bit_slot(1'b1, s);
    bit_slot(1'b1, s);
    check(s == 1'b0, "R7", "first read bit low", s, 0);
    bit_slot(1'b1, s);
    hold(2);
    check(sda_pull == 1'b1, "R7", "driving before reset", sda_pull, 1);
    rst = 1'b1;
    hold(2);
    check(sda_pull == 1'b0, "R1", "released by reset", sda_pull, 0);
    rst = 1'b0;
    m_sda = 1'b1; hold(H/2);
    m_scl = 1'b1; hold(H);
    xfer(7'h5D, 1'b1, 1'b0, 1'b0, 1'b0, 8'h6B);

    hold(20);
    check(reports == 9, "R11", "total reports", reports, 9);
    check(r10_bad == 0, "R10", "SDA changes while SCL high", r10_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule